// File: doc/BRIEF.md
# Data Cache Line Flush Unit

This block takes one 32-bit cache-management instruction word together with the values of its two source registers. It checks that the word encodes the flush-line operation, forms an effective address and looks that address up in a small internal direct-mapped write-back cache with 32-byte lines. Each line of the cache has a tag, a valid bit, a dirty bit and eight 32-bit data words.

A dirty hit sends the whole line out over a word-wide valid/ready memory write port and then invalidates the line. A clean hit invalidates the line without any memory traffic. A miss leaves the cache as it was. A word that fails the encoding check raises an illegal flag and does not touch the cache. The unit holds one instruction at a time: `busy_o` stays high until the `done_o` pulse. A fill port preloads line state for verification.

Top module: `dc_flush_unit`

## Requirements
- R1: An instruction is legal only when instr_i[31:26] = 6'b011111, instr_i[9:1] = 9'd21, and instr_i[25:21], instr_i[10] and instr_i[0] are all zero. The base field is instr_i[20:16] and the index field is instr_i[15:11], so the canonical legal word with both fields zero is 32'h7C00002A. Any other word gives a done pulse with illegal_o = 1, hit_o = 0, no memory beat and no change to the cache.
- R2: When the base field instr_i[20:16] is zero, the effective address is rb_val_i, and ra_val_i has no effect. Otherwise the effective address is ra_val_i + rb_val_i modulo 2^32.
- R3: The line index is address bits [7:5] and the tag is address bits [31:8]. Address bits [4:0] do not affect which line is selected.
- R4: On a dirty hit the unit sends exactly eight beats, word 0 first, each at address {tag, index, word, 2'b00}, carrying the stored word. After the last beat the line is invalid, and done_o comes with hit_o = 1.
- R5: On a clean hit there is no memory beat, the line becomes invalid, and done_o is high in the second cycle after the accepting edge, with hit_o = 1.
- R6: On a miss (line invalid or tag different) there is no memory beat, done_o is high in the second cycle after the accepting edge with hit_o = 0, and the line keeps its state.
- R7: While mem_valid_o is high and mem_ready_i is low, mem_addr_o and mem_data_o hold their values. A beat completes only on a clock edge where both are high.
- R8: done_o is a single-cycle pulse. It follows the last beat of a write-back, or it marks the resolution of a miss, a clean hit or an illegal word. busy_o is high from the cycle after acceptance through the done cycle, and req_valid_i is ignored while busy_o is high.
- R9: After reset, busy_o, done_o and mem_valid_o are low and every line is invalid.
- R10: Each fill_en_i cycle writes fill_data_i to word fill_word_i of line fill_idx_i and sets that line's tag to fill_tag_i, its valid bit to 1 and its dirty bit to fill_dirty_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Instruction request |
| instr_i | input | 32 | Instruction word |
| ra_val_i | input | 32 | Base register value |
| rb_val_i | input | 32 | Index register value |
| busy_o | output | 1 | Instruction in progress |
| done_o | output | 1 | Completion pulse |
| illegal_o | output | 1 | Word rejected, valid with done_o |
| hit_o | output | 1 | Line was present, valid with done_o |
| mem_valid_o | output | 1 | Write beat valid |
| mem_ready_i | input | 1 | Memory accepts beat |
| mem_addr_o | output | 32 | Beat byte address |
| mem_data_o | output | 32 | Beat data |
| fill_en_i | input | 1 | Preload write strobe |
| fill_idx_i | input | 3 | Preload line index |
| fill_word_i | input | 3 | Preload word within line |
| fill_data_i | input | 32 | Preload word data |
| fill_tag_i | input | 24 | Preload tag |
| fill_dirty_i | input | 1 | Preload dirty bit |

## Verification
Every line index is flushed while dirty. Half of these flushes form the address from a non-zero base field and half from a zero base field with an unrelated base value, so a swapped address path shows up as a wrong line or tag. Clean lines, lines with a different tag and invalid lines are each flushed and then flushed again. The second flush shows whether the first one invalidated the line or left it alone. Write-backs run under steady ready and under a stall pattern, which separates correct holding from early advance. Single-bit corruptions of the opcode, the extended opcode and every reserved bit are each followed by a legal flush of a dirty line, which shows that the rejected word left the line untouched.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
  localparam logic [5:0] OPC_MAIN = 6'b011111;
  localparam logic [8:0] OPC_EXT  = 9'd21;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOOK = 2'd1,
    ST_WB   = 2'd2,
    ST_DONE = 2'd3
  } seq_state_e;
endpackage

// File: rtl/dcf_decode.sv
module dcf_decode #(
  parameter int ADDR_W = 32
) (
  input  logic [31:0]       instr_i,
  input  logic [ADDR_W-1:0] ra_val_i,
  input  logic [ADDR_W-1:0] rb_val_i,
  output logic              legal_o,
  output logic [ADDR_W-1:0] ea_o
);
  import dcf_pkg::*;

  logic [4:0]        base_sel;
  logic              rsvd_zero;
  logic [ADDR_W-1:0] base_val;

  // big-endian field numbering: bit 0 is instr_i[31]
  assign base_sel  = instr_i[20:16];
  assign rsvd_zero = (instr_i[25:21] == 5'd0) && !instr_i[10] && !instr_i[0];
  assign legal_o   = (instr_i[31:26] == OPC_MAIN) && (instr_i[9:1] == OPC_EXT) && rsvd_zero;
  // field value zero means literal zero, not register 0
  assign base_val  = (base_sel == 5'd0) ? '0 : ra_val_i;
  assign ea_o      = base_val + rb_val_i;
endmodule

// File: rtl/dcf_store.sv
module dcf_store #(
  parameter int NUM_LINES  = 8,
  parameter int LINE_WORDS = 8,
  parameter int DATA_W     = 32,
  parameter int TAG_W      = 24,
  localparam int IDX_W  = $clog2(NUM_LINES),
  localparam int WSEL_W = $clog2(LINE_WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fill_en_i,
  input  logic [IDX_W-1:0]  fill_idx_i,
  input  logic [WSEL_W-1:0] fill_word_i,
  input  logic [DATA_W-1:0] fill_data_i,
  input  logic [TAG_W-1:0]  fill_tag_i,
  input  logic              fill_dirty_i,
  input  logic              inval_en_i,
  input  logic [IDX_W-1:0]  inval_idx_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  input  logic [WSEL_W-1:0] rd_word_i,
  output logic [TAG_W-1:0]  rd_tag_o,
  output logic              rd_valid_o,
  output logic              rd_dirty_o,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [NUM_LINES-1:0] valid_q;
  logic [NUM_LINES-1:0] dirty_q;
  logic [TAG_W-1:0]     tag_q  [NUM_LINES];
  logic [DATA_W-1:0]    data_q [NUM_LINES][LINE_WORDS];

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
    logic fill_hit, inval_hit;
    assign fill_hit  = fill_en_i  && (fill_idx_i  == IDX_W'(l));
    assign inval_hit = inval_en_i && (inval_idx_i == IDX_W'(l));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q[l] <= 1'b0;
        dirty_q[l] <= 1'b0;
      end else if (inval_hit) begin
        valid_q[l] <= 1'b0;
        dirty_q[l] <= 1'b0;
      end else if (fill_hit) begin
        valid_q[l] <= 1'b1;
        dirty_q[l] <= fill_dirty_i;
      end
    end

    always_ff @(posedge clk_i) begin
      if (fill_hit) begin
        tag_q[l]                <= fill_tag_i;
        data_q[l][fill_word_i]  <= fill_data_i;
      end
    end
  end

  assign rd_tag_o   = tag_q[rd_idx_i];
  assign rd_valid_o = valid_q[rd_idx_i];
  assign rd_dirty_o = dirty_q[rd_idx_i];
  assign rd_data_o  = data_q[rd_idx_i][rd_word_i];

  AST_INVAL_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inval_en_i |=> !valid_q[$past(inval_idx_i)]); // R4
endmodule

// File: rtl/dcf_seq.sv
module dcf_seq #(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int NUM_LINES  = 8,
  parameter int LINE_WORDS = 8,
  localparam int BYTE_W = $clog2(DATA_W/8),
  localparam int WSEL_W = $clog2(LINE_WORDS),
  localparam int OFF_W  = WSEL_W + BYTE_W,
  localparam int IDX_W  = $clog2(NUM_LINES),
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              legal_i,
  input  logic [ADDR_W-1:0] ea_i,
  input  logic [TAG_W-1:0]  rd_tag_i,
  input  logic              rd_valid_i,
  input  logic              rd_dirty_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic [IDX_W-1:0]  rd_idx_o,
  output logic [WSEL_W-1:0] rd_word_o,
  output logic              inval_en_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              illegal_o,
  output logic              hit_o,
  output logic              mem_valid_o,
  input  logic              mem_ready_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_data_o
);
  import dcf_pkg::*;

  localparam logic [WSEL_W-1:0] LAST_WORD = WSEL_W'(LINE_WORDS - 1);

  seq_state_e        state_q;
  logic [TAG_W-1:0]  tag_q;
  logic [IDX_W-1:0]  idx_q;
  logic [WSEL_W-1:0] cnt_q;
  logic              legal_q, hit_q;
  logic              lookup_hit, beat_fire, last_beat;

  assign lookup_hit = legal_q && rd_valid_i && (rd_tag_i == tag_q);
  assign beat_fire  = (state_q == ST_WB) && mem_ready_i;
  assign last_beat  = beat_fire && (cnt_q == LAST_WORD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      tag_q   <= '0;
      idx_q   <= '0;
      cnt_q   <= '0;
      legal_q <= 1'b0;
      hit_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_valid_i) begin
          tag_q   <= ea_i[ADDR_W-1 -: TAG_W];
          idx_q   <= ea_i[OFF_W +: IDX_W];
          legal_q <= legal_i;
          hit_q   <= 1'b0;
          cnt_q   <= '0;
          state_q <= ST_LOOK;
        end
        ST_LOOK: begin
          hit_q   <= lookup_hit;
          state_q <= (lookup_hit && rd_dirty_i) ? ST_WB : ST_DONE;
        end
        ST_WB: if (beat_fire) begin
          cnt_q <= cnt_q + 1'b1;
          if (last_beat) state_q <= ST_DONE;
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // clean hit drops at lookup, dirty hit after the last beat
  assign inval_en_o  = ((state_q == ST_LOOK) && lookup_hit && !rd_dirty_i) || last_beat;
  assign rd_idx_o    = idx_q;
  assign rd_word_o   = cnt_q;
  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = (state_q == ST_DONE);
  assign illegal_o   = done_o && !legal_q;
  assign hit_o       = done_o && hit_q;
  assign mem_valid_o = (state_q == ST_WB);
  assign mem_addr_o  = {tag_q, idx_q, cnt_q, {BYTE_W{1'b0}}};
  assign mem_data_o  = rd_data_i;

  AST_HOLD_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o && !mem_ready_i |=> mem_valid_o && $stable(mem_addr_o) && $stable(mem_data_o)); // R7
  AST_ASCEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o && mem_ready_i && (mem_addr_o[OFF_W-1:BYTE_W] != LAST_WORD)
    |=> mem_valid_o && (mem_addr_o == $past(mem_addr_o) + ADDR_W'(DATA_W/8))); // R4
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R8
  AST_ILLEGAL_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_LOOK) && !legal_q |=> done_o && illegal_o && !mem_valid_o && !inval_en_o); // R1
endmodule

// File: rtl/dc_flush_unit.sv
module dc_flush_unit #(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int NUM_LINES  = 8,
  parameter int LINE_WORDS = 8,
  localparam int BYTE_W = $clog2(DATA_W/8),
  localparam int WSEL_W = $clog2(LINE_WORDS),
  localparam int OFF_W  = WSEL_W + BYTE_W,
  localparam int IDX_W  = $clog2(NUM_LINES),
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [31:0]       instr_i,
  input  logic [ADDR_W-1:0] ra_val_i,
  input  logic [ADDR_W-1:0] rb_val_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              illegal_o,
  output logic              hit_o,
  output logic              mem_valid_o,
  input  logic              mem_ready_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_data_o,
  input  logic              fill_en_i,
  input  logic [IDX_W-1:0]  fill_idx_i,
  input  logic [WSEL_W-1:0] fill_word_i,
  input  logic [DATA_W-1:0] fill_data_i,
  input  logic [TAG_W-1:0]  fill_tag_i,
  input  logic              fill_dirty_i
);
  logic              legal;
  logic [ADDR_W-1:0] ea;
  logic [TAG_W-1:0]  rd_tag;
  logic              rd_valid, rd_dirty, inval_en;
  logic [DATA_W-1:0] rd_data;
  logic [IDX_W-1:0]  rd_idx;
  logic [WSEL_W-1:0] rd_word;

  dcf_decode #(.ADDR_W(ADDR_W)) u_dec (
    .instr_i  (instr_i),
    .ra_val_i (ra_val_i),
    .rb_val_i (rb_val_i),
    .legal_o  (legal),
    .ea_o     (ea)
  );

  dcf_store #(
    .NUM_LINES (NUM_LINES),
    .LINE_WORDS(LINE_WORDS),
    .DATA_W    (DATA_W),
    .TAG_W     (TAG_W)
  ) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fill_en_i   (fill_en_i),
    .fill_idx_i  (fill_idx_i),
    .fill_word_i (fill_word_i),
    .fill_data_i (fill_data_i),
    .fill_tag_i  (fill_tag_i),
    .fill_dirty_i(fill_dirty_i),
    .inval_en_i  (inval_en),
    .inval_idx_i (rd_idx),
    .rd_idx_i    (rd_idx),
    .rd_word_i   (rd_word),
    .rd_tag_o    (rd_tag),
    .rd_valid_o  (rd_valid),
    .rd_dirty_o  (rd_dirty),
    .rd_data_o   (rd_data)
  );

  dcf_seq #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .NUM_LINES (NUM_LINES),
    .LINE_WORDS(LINE_WORDS)
  ) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .legal_i     (legal),
    .ea_i        (ea),
    .rd_tag_i    (rd_tag),
    .rd_valid_i  (rd_valid),
    .rd_dirty_i  (rd_dirty),
    .rd_data_i   (rd_data),
    .rd_idx_o    (rd_idx),
    .rd_word_o   (rd_word),
    .inval_en_o  (inval_en),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .illegal_o   (illegal_o),
    .hit_o       (hit_o),
    .mem_valid_o (mem_valid_o),
    .mem_ready_i (mem_ready_i),
    .mem_addr_o  (mem_addr_o),
    .mem_data_o  (mem_data_o)
  );
endmodule

// File: tb/sim_dc_flush_unit.sv
module sim_dc_flush_unit;
  localparam int K_MISS = 0, K_CLEAN = 1, K_DIRTY = 2, K_ILL = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] instr = '0, ra_val = '0, rb_val = '0;
  logic        busy, done, illegal, hit;
  logic        mem_valid, mem_ready = 1'b0;
  logic [31:0] mem_addr, mem_data;
  logic        fill_en = 1'b0;
  logic [2:0]  fill_idx = '0, fill_word = '0;
  logic [31:0] fill_data = '0;
  logic [23:0] fill_tag = '0;
  logic        fill_dirty = 1'b0;

  int n_tests = 0, n_fail = 0;

  always #5 clk = ~clk;

  dc_flush_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .instr_i(instr),
    .ra_val_i(ra_val), .rb_val_i(rb_val), .busy_o(busy), .done_o(done),
    .illegal_o(illegal), .hit_o(hit), .mem_valid_o(mem_valid),
    .mem_ready_i(mem_ready), .mem_addr_o(mem_addr), .mem_data_o(mem_data),
    .fill_en_i(fill_en), .fill_idx_i(fill_idx), .fill_word_i(fill_word),
    .fill_data_i(fill_data), .fill_tag_i(fill_tag), .fill_dirty_i(fill_dirty)
  );

  function automatic logic [31:0] pat(int idx, int w, logic [23:0] tag);
    return {tag[11:0], 4'(w), 8'(idx), 8'hC3} ^ 32'h5A00_0000;
  endfunction

  function automatic logic [31:0] iword(logic [4:0] ra_f, logic [4:0] rb_f);
    return 32'h7C00_002A | (32'(ra_f) << 16) | (32'(rb_f) << 11);
  endfunction

  function automatic logic [31:0] mk_ea(logic [23:0] tag, int idx, int off);
    return {tag, 3'(idx), 5'(off)};
  endfunction

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic fill_line(int idx, logic [23:0] tag, bit dirty);
    for (int w = 0; w < 8; w++) begin
      @(negedge clk);
      fill_en = 1'b1; fill_idx = 3'(idx); fill_word = 3'(w);
      fill_data = pat(idx, w, tag); fill_tag = tag; fill_dirty = dirty;
    end
    @(negedge clk);
    fill_en = 1'b0;
  endtask

  // kind: expected outcome; etag/eidx: line expected on the port
  task automatic flush(logic [31:0] ins, logic [31:0] ra, logic [31:0] rb, int kind,
                       logic [23:0] etag, int eidx, bit stall, bit inject,
                       logic [31:0] inj_rb, string req);
    int beats = 0, cyc = 1, done_cyc = -1;
    bit hold_prev = 0, busy_bad = 0, got_done = 0, seen_hit = 0, seen_ill = 0;
    logic [31:0] pa = '0, pd = '0, ea_exp, ed_exp;
    @(negedge clk);
    req_valid = 1'b1; instr = ins; ra_val = ra; rb_val = rb;
    @(negedge clk);
    req_valid = 1'b0;
    while (!got_done && cyc < 200) begin
      if (!busy) busy_bad = 1;
      if (hold_prev)
        chk(mem_valid && mem_addr == pa && mem_data == pd, "R7", "stalled beat held", mem_addr, pa);
      if (inject && cyc == 3) begin
        req_valid = 1'b1; instr = iword(5'd0, 5'd4); rb_val = inj_rb;
      end
      if (inject && cyc == 4) req_valid = 1'b0;
      mem_ready = stall ? (cyc % 3 == 0) : 1'b1;
      if (mem_valid) begin
        ea_exp = {etag, 3'(eidx), 3'(beats), 2'b00};
        ed_exp = pat(eidx, beats, etag);
        if (beats >= 8) chk(0, "R4", "extra beat", 32'(beats), 32'd8);
        else begin
          chk(mem_addr == ea_exp, "R4", "beat address", mem_addr, ea_exp);
          chk(mem_data == ed_exp, "R4", "beat data", mem_data, ed_exp);
        end
        hold_prev = !mem_ready; pa = mem_addr; pd = mem_data;
        if (mem_ready) beats++;
      end else hold_prev = 0;
      if (done) begin
        got_done = 1; done_cyc = cyc; seen_hit = hit; seen_ill = illegal;
      end else begin
        @(negedge clk);
        cyc++;
      end
    end
    @(negedge clk);
    mem_ready = 1'b0;
    chk(!done && !busy, "R8", {req, " done single pulse / busy released"}, {30'd0, done, busy}, 32'd0);
    chk(!busy_bad, "R8", {req, " busy held through operation"}, 32'(busy_bad), 32'd0);
    chk(got_done, req, "done seen", 32'(got_done), 32'd1);
    chk(beats == ((kind == K_DIRTY) ? 8 : 0), req, "beat count", 32'(beats),
        (kind == K_DIRTY) ? 32'd8 : 32'd0);
    chk(seen_hit == (kind == K_DIRTY || kind == K_CLEAN), req, "hit flag", 32'(seen_hit),
        32'(kind == K_DIRTY || kind == K_CLEAN));
    chk(seen_ill == (kind == K_ILL), req, "illegal flag", 32'(seen_ill), 32'(kind == K_ILL));
    if (kind != K_DIRTY)
      chk(done_cyc == 2, req, "done latency", 32'(done_cyc), 32'd2);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [23:0] t;
    logic [31:0] e, rb;
    logic [31:0] bad [6];
    repeat (3) @(negedge clk);
    chk(!busy && !done && !mem_valid, "R9", "reset outputs", {29'd0, busy, done, mem_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R9: every line starts invalid
    for (int i = 0; i < 8; i++)
      flush(iword(5'd0, 5'd2), 32'hDEAD_BEEF, mk_ea(24'd0, i, 0), K_MISS, 24'd0, i, 0, 0, 0, "R9");

    // R4/R2/R3/R10: dirty line per index, address from both paths
    for (int i = 0; i < 8; i++) begin
      t = 24'(i * 24'h01357 + 5);
      fill_line(i, t, 1);
      e = mk_ea(t, i, i * 3 + 1);
      if (i % 2 == 0) begin
        rb = 32'h1234_5678 * 32'(i + 1);
        flush(iword(5'd3, 5'd4), e - rb, rb, K_DIRTY, t, i, i % 4 == 0, 0, 0, "R2");
      end else
        flush(iword(5'd0, 5'd4), 32'hFFFF_0000 + 32'(i), e, K_DIRTY, t, i, 1, 0, 0, "R3");
      flush(iword(5'd0, 5'd4), 0, e, K_MISS, t, i, 0, 0, 0, "R4");
    end

    // R5: clean hits invalidated without traffic
    for (int i = 0; i < 8; i++) begin
      t = 24'hABC000 + 24'(i);
      fill_line(i, t, 0);
      flush(iword(5'd0, 5'd1), 32'h7777_7777, mk_ea(t, i, 31 - i), K_CLEAN, t, i, 0, 0, 0, "R5");
      flush(iword(5'd0, 5'd1), 0, mk_ea(t, i, 0), K_MISS, t, i, 0, 0, 0, "R5");
    end

    // R6: tag mismatch leaves line dirty
    fill_line(5, 24'h00F00D, 1);
    flush(iword(5'd0, 5'd1), 0, mk_ea(24'h00F00E, 5, 0), K_MISS, 24'h00F00E, 5, 0, 0, 0, "R6");
    flush(iword(5'd0, 5'd1), 0, mk_ea(24'h00F00D, 5, 8), K_DIRTY, 24'h00F00D, 5, 0, 0, 0, "R6");

    // R1: corrupted opcode, extended opcode, reserved bits
    bad[0] = 32'h0400_0000; bad[1] = 32'h0000_0002; bad[2] = 32'h0200_0000;
    bad[3] = 32'h0020_0000; bad[4] = 32'h0000_0400; bad[5] = 32'h0000_0001;
    fill_line(2, 24'h0BAD00, 1);
    for (int k = 0; k < 6; k++)
      flush(iword(5'd0, 5'd1) ^ bad[k], 0, mk_ea(24'h0BAD00, 2, 0), K_ILL, 24'h0, 2, 0, 0, 0, "R1");
    flush(iword(5'd0, 5'd1), 0, mk_ea(24'h0BAD00, 2, 4), K_DIRTY, 24'h0BAD00, 2, 1, 0, 0, "R1");

    // R2: modular sum wraps to idx 1 tag 0
    fill_line(1, 24'h000000, 1);
    flush(iword(5'd9, 5'd1), 32'hFFFF_FFF0, 32'h0000_0030, K_DIRTY, 24'h0, 1, 0, 0, 0, "R2");

    // R8: request during busy is ignored
    fill_line(3, 24'h111111, 1);
    fill_line(4, 24'h222222, 1);
    flush(iword(5'd0, 5'd1), 0, mk_ea(24'h111111, 3, 0), K_DIRTY, 24'h111111, 3, 1, 1,
          mk_ea(24'h222222, 4, 0), "R8");
    flush(iword(5'd0, 5'd1), 0, mk_ea(24'h222222, 4, 0), K_DIRTY, 24'h222222, 4, 0, 0, 0, "R8");

    finish_run();
  end
endmodule